// File: doc/BRIEF.md
# Prioritized Task Trigger Scheduler

This block picks which of eight software tasks an accelerator core runs next. Every task has its own hardware event line, for example a timer tick or an ADC conversion-complete strobe. A host-controlled force bit per task does the same job as that event line. Each request is latched as a pending flag. Among the pending tasks that are enabled, the one with the highest priority is offered to the core over a valid/ready dispatch channel that carries the task index. A foreground task that the core accepts runs until the core pulses `done_i`. Foreground tasks never nest.

When background mode is on, the lowest-priority slot (index 7) becomes a background task. After it is dispatched it runs continuously and ends only when `terminate_i` is pulsed or the block is reset. Any foreground task that is dispatched while the background task is running carries a preempt flag, so the core knows it must set the background context aside. Further foreground tasks are then served in priority order. When no foreground task is pending or running, `resume_o` is pulsed for one cycle. While the background task holds `bg_unint_i` high, foreground tasks stay pending and are not offered.

Back-pressure rule: `dispatch_valid_o` stays high, with the task index and preempt flag unchanged, until the core raises `dispatch_ready_i`. The handshake completes on a clock edge where both are high. No other offer is made while one is outstanding.

Top module: `task_dispatch_sched`

## Requirements
- R1: After reset, these outputs are all low: `dispatch_valid_o`, `dispatch_preempt_o`, `resume_o`, `bg_running_o` and every bit of `overflow_o`.
- R2: A task's trigger or force bit sampled high at clock edge k sets its pending flag. If the scheduler is idle (no offer outstanding, no foreground task running), `dispatch_valid_o` goes high after edge k+1 with `dispatch_task_o` equal to the task's index (0..7).
- R3: If several tasks are pending and enabled, the lowest index wins: index 0 has the highest priority and index 7 the lowest. A pending task whose enable bit is low is not offered, but it stays pending until it is enabled again.
- R4: Once `dispatch_valid_o` is high, it stays high with a stable task index and preempt flag until an edge where `dispatch_ready_i` is high. The offer is withdrawn after that edge.
- R5: After a foreground task is accepted, no new offer is made until `done_i` has been sampled high. The next offer appears one cycle after that edge at the earliest.
- R6: A trigger or force for a task that is already pending, offered or running sets that task's bit in `overflow_o`. That bit stays set until reset. No second request is queued.
- R7: With `bg_mode_i` high, an accepted offer of index 7 starts the background task. `bg_running_o` then stays high until `terminate_i`, and `done_i` has no effect on it.
- R8: A foreground task offered while the background task is running and not already preempted has `dispatch_preempt_o` high.
- R9: After a preemption, further foreground tasks are offered without the preempt flag. One cycle after the scheduler becomes idle with no enabled foreground task pending, `resume_o` is pulsed high for exactly one cycle.
- R10: While the background task is running, not preempted, and `bg_unint_i` is high, no offer is made. A held task is offered one cycle after `bg_unint_i` is sampled low.
- R11: `terminate_i` ends the background task, including one that is currently preempted. No `resume_o` follows. Index 7 can then be triggered and dispatched again.
- R12: With `bg_mode_i` low, index 7 behaves as an ordinary foreground task: it ends on `done_i` and never raises `bg_running_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 8 | Hardware event lines, one per task |
| force_i | input | 8 | Host force bits, act like triggers |
| enable_i | input | 8 | Per-task dispatch enable |
| bg_mode_i | input | 1 | Treat index 7 as background task |
| terminate_i | input | 1 | End the background task |
| bg_unint_i | input | 1 | Background task is in an uninterruptible section |
| dispatch_valid_o | output | 1 | Task offer valid |
| dispatch_ready_i | input | 1 | Core accepts the offer |
| dispatch_task_o | output | 3 | Index of the offered task |
| dispatch_preempt_o | output | 1 | Offer preempts the background task |
| done_i | input | 1 | Running foreground task has completed |
| resume_o | output | 1 | One-cycle pulse: core may resume the background task |
| bg_running_o | output | 1 | Background task is active (running or preempted) |
| overflow_o | output | 8 | Sticky per-task lost-trigger flags |

## Verification
Some properties are checked by assertions on every cycle:
- an offer is held stable under back-pressure;
- no offer is made while a foreground task runs or while an uninterruptible section shields the background task;
- overflow bits are sticky, and a task is never both pending and occupied;
- grants are one-hot and lowest-index-first;
- a resume comes only while the background task is still active.

The bench scenarios are the only place where the following can be shown: exact dispatch latency from a trigger, disabled tasks staying pending, the chain of preemption, a second foreground task and resume, the effect of terminating a preempted background task, and index 7 acting as a plain task when background mode is off.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int NTASK  = 8;
  localparam int TIDX_W = $clog2(NTASK);
  localparam int BG_IDX = NTASK - 1;

  typedef logic [TIDX_W-1:0] task_idx_t;
  typedef logic [NTASK-1:0]  task_vec_t;

  typedef struct packed {
    logic      valid;
    logic      bg;
    logic      preempt;
    task_idx_t idx;
  } offer_t;
endpackage

// File: rtl/sched_trig_latch.sv
module sched_trig_latch
  import sched_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  task_vec_t req,
  input  task_vec_t occ,
  input  task_vec_t clr,
  output task_vec_t pend,
  output task_vec_t ovf
);
  for (genvar i = 0; i < NTASK; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        ovf[i]  <= 1'b0;
      end else begin
        if (req[i] && (pend[i] || occ[i])) ovf[i] <= 1'b1;
        if (clr[i])                        pend[i] <= 1'b0;
        else if (req[i] && !occ[i])        pend[i] <= 1'b1;
      end
    end

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[i] |=> ovf[i]);
  end

  // a task is never pending while it is also offered or running
  assert_no_dup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & occ) == '0);
endmodule

// File: rtl/sched_prio_pick.sv
module sched_prio_pick
  import sched_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  task_vec_t req,
  output logic      any,
  output task_idx_t idx,
  output task_vec_t grant
);
  logic [NTASK:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NTASK; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[NTASK];

  always_comb begin
    idx = '0;
    for (int i = NTASK - 1; i >= 0; i--) begin
      if (req[i]) idx = task_idx_t'(i);
    end
  end

  assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> grant[idx]);
endmodule

// File: rtl/sched_dispatch_ctrl.sv
module sched_dispatch_ctrl
  import sched_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  task_vec_t pend,
  input  task_vec_t enable,
  input  logic      bg_mode,
  input  logic      bg_unint,
  input  logic      terminate,
  input  logic      ready,
  input  logic      done,
  input  logic      pick_any,
  input  task_idx_t pick_idx,
  input  task_vec_t pick_grant,
  output task_vec_t cand,
  output task_vec_t clr,
  output task_vec_t occ,
  output offer_t    offer,
  output logic      resume,
  output logic      bg_active
);
  offer_t    offer_q;
  logic      fg_busy, bg_run, bg_susp, resume_q;
  task_idx_t fg_idx;

  task_vec_t fg_mask, fg_cand;
  logic      bg_cand, idle, shield, fire, accept, resume_cond;

  always_comb begin
    fg_mask = '1;
    if (bg_mode) fg_mask[BG_IDX] = 1'b0;
  end

  assign fg_cand = pend & enable & fg_mask;
  assign bg_cand = bg_mode && pend[BG_IDX] && enable[BG_IDX] && !bg_run;

  always_comb begin
    cand = fg_cand;
    cand[BG_IDX] = fg_cand[BG_IDX] | bg_cand;
  end

  assign idle        = !offer_q.valid && !fg_busy;
  assign shield      = bg_run && !bg_susp && bg_unint;
  assign fire        = idle && !shield && pick_any;
  assign accept      = offer_q.valid && ready;
  assign resume_cond = bg_susp && idle && (fg_cand == '0);
  assign clr         = fire ? pick_grant : '0;

  for (genvar i = 0; i < NTASK; i++) begin : g_occ
    if (i == BG_IDX) begin : g_bg
      assign occ[i] = (offer_q.valid && offer_q.idx == task_idx_t'(i)) ||
                      (fg_busy && fg_idx == task_idx_t'(i)) || bg_run;
    end else begin : g_fg
      assign occ[i] = (offer_q.valid && offer_q.idx == task_idx_t'(i)) ||
                      (fg_busy && fg_idx == task_idx_t'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offer_q  <= '0;
      fg_busy  <= 1'b0;
      fg_idx   <= '0;
      bg_run   <= 1'b0;
      bg_susp  <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      if (fire) begin
        offer_q.valid   <= 1'b1;
        offer_q.idx     <= pick_idx;
        offer_q.bg      <= bg_mode && (pick_idx == task_idx_t'(BG_IDX));
        offer_q.preempt <= bg_run && !bg_susp;
      end else if (accept) begin
        offer_q.valid <= 1'b0;
      end

      if (accept && !offer_q.bg) begin
        fg_busy <= 1'b1;
        fg_idx  <= offer_q.idx;
      end else if (done && fg_busy) begin
        fg_busy <= 1'b0;
      end

      if (terminate)                  bg_run <= 1'b0;
      else if (accept && offer_q.bg)  bg_run <= 1'b1;

      if (terminate)                  bg_susp <= 1'b0;
      else if (fire && bg_run)        bg_susp <= 1'b1;
      else if (resume_cond)           bg_susp <= 1'b0;

      resume_q <= resume_cond && !terminate;
    end
  end

  assign offer     = offer_q;
  assign resume    = resume_q;
  assign bg_active = bg_run;

  assert_offer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    offer_q.valid && !ready |=> offer_q.valid && $stable(offer_q.idx) && $stable(offer_q.preempt));
  assert_run_to_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fg_busy |-> !offer_q.valid);
  assert_shield_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shield |=> !$rose(offer_q.valid));
  assert_resume_ctx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resume_q |-> bg_run && !bg_susp && !fg_busy);
  assert_preempt_ctx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    offer_q.valid && offer_q.preempt && bg_run |-> bg_susp);
endmodule

// File: rtl/task_dispatch_sched.sv
module task_dispatch_sched
  import sched_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTASK-1:0]  trig_i,
  input  logic [NTASK-1:0]  force_i,
  input  logic [NTASK-1:0]  enable_i,
  input  logic              bg_mode_i,
  input  logic              terminate_i,
  input  logic              bg_unint_i,
  output logic              dispatch_valid_o,
  input  logic              dispatch_ready_i,
  output logic [TIDX_W-1:0] dispatch_task_o,
  output logic              dispatch_preempt_o,
  input  logic              done_i,
  output logic              resume_o,
  output logic              bg_running_o,
  output logic [NTASK-1:0]  overflow_o
);
  task_vec_t req, pend, occ, clr, cand, grant;
  logic      pick_any;
  task_idx_t pick_idx;
  offer_t    offer;

  assign req = trig_i | force_i;

  sched_trig_latch u_latch (
    .clk(clk), .rst_n(rst_n), .req(req), .occ(occ), .clr(clr),
    .pend(pend), .ovf(overflow_o)
  );

  sched_prio_pick u_pick (
    .clk(clk), .rst_n(rst_n), .req(cand),
    .any(pick_any), .idx(pick_idx), .grant(grant)
  );

  sched_dispatch_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pend(pend), .enable(enable_i),
    .bg_mode(bg_mode_i), .bg_unint(bg_unint_i), .terminate(terminate_i),
    .ready(dispatch_ready_i), .done(done_i),
    .pick_any(pick_any), .pick_idx(pick_idx), .pick_grant(grant),
    .cand(cand), .clr(clr), .occ(occ), .offer(offer),
    .resume(resume_o), .bg_active(bg_running_o)
  );

  assign dispatch_valid_o   = offer.valid;
  assign dispatch_task_o    = offer.idx;
  assign dispatch_preempt_o = offer.preempt;
endmodule

// File: tb/test_task_dispatch_sched.sv
module test_task_dispatch_sched;
  import sched_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int LAST = NTASK - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NTASK-1:0] trig = '0, frc = '0, en = '0;
  logic bgm = 1'b0, term = 1'b0, unint = 1'b0, ready = 1'b0, done = 1'b0;
  logic d_valid, d_pre, resume, bg_run;
  logic [TIDX_W-1:0] d_task;
  logic [NTASK-1:0] ovf;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  task_dispatch_sched i_task_dispatch_sched (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .force_i(frc), .enable_i(en),
    .bg_mode_i(bgm), .terminate_i(term), .bg_unint_i(unint),
    .dispatch_valid_o(d_valid), .dispatch_ready_i(ready), .dispatch_task_o(d_task),
    .dispatch_preempt_o(d_pre), .done_i(done), .resume_o(resume),
    .bg_running_o(bg_run), .overflow_o(ovf)
  );

  // behavioural reference model
  bit m_pend[NTASK], m_ovf[NTASK];
  bit m_valid, m_pre, m_isbg, m_busy, m_bg, m_susp, m_res;
  int m_task, m_run;

  always @(posedge clk) begin : model
    bit req[NTASK], occ[NTASK];
    bit idle, shield, acc, fgany, rc, fire_now;
    int pick;
    if (!rst_n) begin
      for (int i = 0; i < NTASK; i++) begin m_pend[i] = 0; m_ovf[i] = 0; end
      m_valid = 0; m_pre = 0; m_isbg = 0; m_busy = 0; m_bg = 0; m_susp = 0; m_res = 0;
      m_task = 0; m_run = 0;
    end else begin
      idle = !m_valid && !m_busy;
      shield = m_bg && !m_susp && unint;
      acc = m_valid && ready;
      pick = -1; fgany = 0;
      for (int i = 0; i < NTASK; i++) begin
        req[i] = trig[i] | frc[i];
        occ[i] = (m_valid && m_task == i) || (m_busy && m_run == i) || (i == LAST && m_bg);
        if (m_pend[i] && en[i] && !(bgm && i == LAST)) fgany = 1;
        if (pick < 0 && m_pend[i] && en[i] && !(bgm && i == LAST && m_bg)) pick = i;
      end
      fire_now = idle && !shield && pick >= 0;
      rc = m_susp && idle && !fgany;
      for (int i = 0; i < NTASK; i++) begin
        if (req[i] && (m_pend[i] || occ[i])) m_ovf[i] = 1;
        if (fire_now && pick == i) m_pend[i] = 0;
        else if (req[i] && !occ[i]) m_pend[i] = 1;
      end
      m_res = rc && !term;
      if (acc && !m_isbg) begin m_busy = 1; m_run = m_task; end
      else if (done && m_busy) m_busy = 0;
      if (acc && m_isbg) m_bg = 1;
      if (fire_now) begin
        m_valid = 1; m_task = pick; m_isbg = bgm && pick == LAST; m_pre = m_bg && !m_susp;
        if (m_bg) m_susp = 1;
      end else if (acc) m_valid = 0;
      if (rc) m_susp = 0;
      if (term) begin m_bg = 0; m_susp = 0; end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int mo;
      mo = 0;
      for (int i = 0; i < NTASK; i++) if (m_ovf[i]) mo |= (1 << i);
      check("R4 valid vs model", d_valid, m_valid);
      if (m_valid) begin
        check("R3 task vs model", d_task, m_task);
        check("R8 preempt vs model", d_pre, m_pre);
      end
      check("R9 resume vs model", resume, m_res);
      check("R6 overflow vs model", ovf, mo);
      check("R7 bg_running vs model", bg_run, m_bg);
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_trig(int t); trig[t] = 1'b1; cyc(1); trig = '0; endtask
  task automatic do_accept(); ready = 1'b1; cyc(1); ready = 1'b0; endtask
  task automatic do_done(); done = 1'b1; cyc(1); done = 1'b0; endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check("R1 valid", d_valid, 0);
    check("R1 preempt", d_pre, 0);
    check("R1 resume", resume, 0);
    check("R1 bg_running", bg_run, 0);
    check("R1 overflow", ovf, 0);
    en = '1;

    // latency and back-pressure
    pulse_trig(2);
    check("R2 not yet offered", d_valid, 0);
    cyc(1);
    check("R2 offered", d_valid, 1);
    check("R2 task", d_task, 2);
    cyc(3);
    check("R4 held valid", d_valid, 1);
    check("R4 held task", d_task, 2);
    do_accept();
    check("R4 withdrawn", d_valid, 0);

    // run to completion and overflow
    pulse_trig(0);
    pulse_trig(0);
    check("R6 overflow bit0", ovf[0], 1);
    cyc(2);
    check("R5 no offer while running", d_valid, 0);
    do_done();
    check("R5 not before next cycle", d_valid, 0);
    cyc(1);
    check("R5 next offer", d_valid, 1);
    check("R5 next task", d_task, 0);
    do_accept();
    do_done();
    cyc(2);
    check("R6 no second request", d_valid, 0);

    // priority with a disabled task and a force bit
    en[1] = 1'b0;
    trig[1] = 1'b1; trig[3] = 1'b1; frc[5] = 1'b1;
    cyc(1);
    trig = '0; frc = '0;
    cyc(1);
    check("R3 lowest enabled index", d_task, 3);
    do_accept();
    do_done();
    cyc(1);
    check("R2 forced task", d_task, 5);
    do_accept();
    do_done();
    en[1] = 1'b1;
    cyc(1);
    check("R3 disabled task kept pending", d_valid, 1);
    check("R3 re-enabled task", d_task, 1);
    do_accept();
    do_done();

    // index 7 as foreground
    pulse_trig(LAST);
    cyc(1);
    check("R12 offered", d_task, LAST);
    do_accept();
    check("R12 no background", bg_run, 0);
    do_done();
    cyc(2);
    check("R12 no resume", resume, 0);
    check("R12 idle", d_valid, 0);

    // background task
    bgm = 1'b1;
    pulse_trig(LAST);
    cyc(1);
    check("R7 offered", d_task, LAST);
    do_accept();
    check("R7 running", bg_run, 1);
    do_done();
    check("R7 done ignored", bg_run, 1);
    pulse_trig(LAST);
    check("R7 overflow on retrigger", ovf[LAST], 1);

    // preemption chain and resume
    pulse_trig(4);
    cyc(1);
    check("R8 preempting task", d_task, 4);
    check("R8 preempt flag", d_pre, 1);
    do_accept();
    pulse_trig(2);
    cyc(1);
    do_done();
    check("R9 no early resume", resume, 0);
    cyc(1);
    check("R9 second task", d_task, 2);
    check("R9 second task not preempting", d_pre, 0);
    do_accept();
    do_done();
    cyc(1);
    check("R9 resume pulse", resume, 1);
    cyc(1);
    check("R9 resume one cycle", resume, 0);

    // uninterruptible section
    unint = 1'b1;
    pulse_trig(0);
    cyc(3);
    check("R10 held", d_valid, 0);
    unint = 1'b0;
    cyc(1);
    check("R10 released", d_valid, 1);
    check("R10 task", d_task, 0);
    check("R10 preempt", d_pre, 1);
    do_accept();
    do_done();
    cyc(1);
    check("R10 resume", resume, 1);

    // terminate a preempted background task
    pulse_trig(6);
    cyc(1);
    do_accept();
    term = 1'b1;
    cyc(1);
    term = 1'b0;
    check("R11 ended", bg_run, 0);
    do_done();
    cyc(2);
    check("R11 no resume", resume, 0);
    pulse_trig(LAST);
    cyc(1);
    check("R11 restart offered", d_valid, 1);
    check("R11 restart task", d_task, LAST);
    do_accept();
    check("R11 running again", bg_run, 1);
    term = 1'b1;
    cyc(1);
    term = 1'b0;
    cyc(1);
    check("R11 terminated", bg_run, 0);

    finished = 1;
    report();
  end
endmodule